// File: doc/BRIEF.md
# TDMA Frame and Slot Sequencer

This block is the local time base of a node that shares a radio channel by time division. A cycle counter runs inside each slot, and a slot counter runs inside each frame. The first slots of every frame form one contiguous active run; the remaining slots are sleep slots with the radio powered down. Within the active run, one slot may be the node's own transmit slot and all others are receive slots. The block reports the kind of the current slot and drives radio receive enable, radio transmit enable and a transmit-permit strobe. Inside the transmit slot it leaves room for radio turnaround at both ends and narrows the transmit permission further by a guard interval.

A signed cycle correction, computed elsewhere from the timing of received messages, can be handed in at any time. It is held pending and applied once, at the moment the schedule enters the first sleep slot. A positive value moves time forward inside that slot; a negative value holds time back. Both are clamped to less than one slot length, so the frame boundary is never skipped. The slot length, the frame length in slots, the active-slot count, the transmit slot, the guard and the turnaround come from configuration ports. They are expected to change only while reset is held.

Top module: `tdma_seq`

## Requirements
- R1: Without correction every slot lasts `cfg_slot_len` cycles and `slot_num` steps 0, 1, …, `cfg_frame_slots`-1, then wraps to 0. The last cycle with `rst` high counts as cycle 0 of slot 0.
- R2: `frame_start` is a one-cycle pulse in the first cycle of slot 0 of every frame that follows a wrap.
- R3: `active` is high exactly while `slot_num` < `cfg_active_slots`.
- R4: When 1 ≤ `cfg_active_slots` < `cfg_frame_slots`, `active_done` pulses for one cycle in the first cycle of slot `cfg_active_slots`. Otherwise it never pulses.
- R5: `slot_kind` encodes 0 = sleep, 1 = receive, 2 = transmit. In every active slot other than the transmit slot, `radio_rx_en` is high for the whole slot and `radio_tx_en` is low.
- R6: In sleep slots `radio_rx_en`, `radio_tx_en` and `tx_permit` are all low.
- R7: In the transmit slot `radio_rx_en` is low. `radio_tx_en` is high at cycle index c exactly when c ≥ `cfg_turnaround` and c + `cfg_turnaround` ≤ `cfg_slot_len`-1.
- R8: In the transmit slot `tx_permit` is high at cycle index c exactly when c ≥ `cfg_guard` and c + `cfg_guard` ≤ `cfg_slot_len`-1.
- R9: If `cfg_tx_slot` ≥ `cfg_active_slots`, no slot is of kind transmit. Every active slot is then a receive slot, and `radio_tx_en` and `tx_permit` stay low.
- R10: A value presented with `corr_valid` is held pending, and a later one replaces it. The pending value is used at the entry into slot `cfg_active_slots` (only when 1 ≤ `cfg_active_slots` < `cfg_frame_slots`), and the pending state is then cleared. A positive value c makes that slot's first cycle index min(c, `cfg_slot_len`-1). A value given in the entry cycle itself stays pending for the next frame.
- R11: A negative pending value c holds cycle 0 of slot `cfg_active_slots` for min(−c, `cfg_slot_len`-1) extra cycles. A zero value has no effect.
- R12: While `rst` is high, all outputs are 0 and the counters restart at slot 0, cycle 0 with no correction pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slot_len | input | CYC_W | Cycles per slot (≥ 1) |
| cfg_frame_slots | input | SLOT_W | Slots per frame (≥ 1) |
| cfg_active_slots | input | SLOT_W | Length of the active run at frame start |
| cfg_tx_slot | input | SLOT_W | Own transmit slot index |
| cfg_guard | input | CYC_W | Guard cycles at each end of transmit permission |
| cfg_turnaround | input | CYC_W | Radio turnaround cycles at each end of the transmit slot |
| corr_valid | input | 1 | Load a new pending correction |
| corr_value | input | CORR_W | Signed correction in cycles |
| slot_num | output | SLOT_W | Current slot index |
| frame_start | output | 1 | First-cycle-of-frame pulse |
| active | output | 1 | Current slot is in the active run |
| active_done | output | 1 | First-cycle-of-sleep pulse |
| slot_kind | output | 2 | 0 sleep, 1 receive, 2 transmit |
| radio_rx_en | output | 1 | Radio receiver enable |
| radio_tx_en | output | 1 | Radio transmitter enable |
| tx_permit | output | 1 | Transmission of data allowed |

## Verification
The assertions assume that the configuration is stable outside reset. They also assume `cfg_slot_len` and `cfg_frame_slots` are at least 1, that `cfg_turnaround` ≤ `cfg_guard`, and that twice the guard is below the slot length. Otherwise transmit permission could not sit inside transmit enable. The stimulus draws each configuration inside these bounds and changes it only while reset is asserted. It also places the transmit slot both inside and just past the active run, and uses active counts of zero and of the full frame. Corrections are drawn from a range wider than one slot on both sides, so the clamps are reached in both directions.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  typedef enum logic [1:0] {
    SK_SLEEP = 2'd0,
    SK_RX    = 2'd1,
    SK_TX    = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/tdma_corr_unit.sv
// Holds the pending signed correction and produces the clamped forward skip
// or backward hold amounts used at the entry into the first sleep slot.
module tdma_corr_unit #(
  parameter int CYC_W  = 12,
  parameter int CORR_W = CYC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     corr_valid,
  input  logic signed [CORR_W-1:0] corr_value,
  input  logic                     consume,
  input  logic [CYC_W-1:0]         slot_len,
  output logic [CYC_W-1:0]         skip_cyc,
  output logic [CYC_W-1:0]         hold_cyc
);

  localparam int MAG_W = CORR_W + 1;

  logic                     pend_q;
  logic signed [CORR_W-1:0] corr_q;
  logic [MAG_W-1:0]         mag;
  logic [MAG_W-1:0]         lim;
  logic [MAG_W-1:0]         clamped;
  logic                     neg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      corr_q <= '0;
    end else if (corr_valid) begin
      pend_q <= 1'b1;
      corr_q <= corr_value;
    end else if (consume) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    neg     = corr_q[CORR_W-1];
    lim     = {{(MAG_W-CYC_W){1'b0}}, slot_len} - 1'b1;
    mag     = neg ? (~{1'b1, corr_q} + 1'b1) : {1'b0, corr_q};
    clamped = (mag > lim) ? lim : mag;
    skip_cyc = (pend_q && !neg) ? clamped[CYC_W-1:0] : '0;
    hold_cyc = (pend_q &&  neg) ? clamped[CYC_W-1:0] : '0;
  end

endmodule

// File: rtl/tdma_slot_counter.sv
// Cycle-within-slot and slot-within-frame counters, with the once-per-frame
// correction applied when the first sleep slot is entered.
module tdma_slot_counter #(
  parameter int CYC_W  = 12,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cfg_slot_len,
  input  logic [SLOT_W-1:0] cfg_frame_slots,
  input  logic [SLOT_W-1:0] cfg_active_slots,
  input  logic [CYC_W-1:0]  skip_cyc,
  input  logic [CYC_W-1:0]  hold_cyc,
  output logic              enter_sleep,
  output logic              frame_wrap,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_n,
  output logic [CYC_W-1:0]  cyc_n
);

  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-1:0] stall_q;
  logic [CYC_W-1:0] stall_n;
  logic [CYC_W-1:0] last_cyc;
  logic             slot_end;
  logic             has_sleep;

  always_comb begin
    last_cyc    = cfg_slot_len - 1'b1;
    slot_end    = (stall_q == '0) && (cyc_q >= last_cyc);
    frame_wrap  = slot_end && (slot_q >= cfg_frame_slots - 1'b1);
    has_sleep   = (cfg_active_slots != '0) && (cfg_active_slots < cfg_frame_slots);
    enter_sleep = slot_end && has_sleep && (slot_q == cfg_active_slots - 1'b1);

    slot_n  = slot_q;
    cyc_n   = cyc_q;
    stall_n = stall_q;
    if (stall_q != '0) begin
      stall_n = stall_q - 1'b1;
    end else if (slot_end) begin
      cyc_n  = '0;
      slot_n = frame_wrap ? '0 : slot_q + 1'b1;
      if (enter_sleep) begin
        cyc_n   = skip_cyc;
        stall_n = hold_cyc;
      end
    end else begin
      cyc_n = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      cyc_q   <= '0;
      stall_q <= '0;
    end else begin
      slot_q  <= slot_n;
      cyc_q   <= cyc_n;
      stall_q <= stall_n;
    end
  end

  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    slot_q < cfg_frame_slots); // R1

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot_q != $past(slot_q)) |-> ((slot_q == $past(slot_q) + 1'b1) || (slot_q == '0))); // R1

  AST_CYC_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    cyc_q < cfg_slot_len); // R10

  AST_HOLD_ONLY_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (stall_q != '0) |-> ((slot_q == cfg_active_slots) && (cyc_q == '0))); // R11

endmodule

// File: rtl/tdma_radio_ctl.sv
// Decodes the upcoming slot position into registered slot kind and radio
// controls, so every output changes together with the slot counter.
module tdma_radio_ctl
  import tdma_pkg::*;
#(
  parameter int CYC_W  = 12,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cfg_slot_len,
  input  logic [SLOT_W-1:0] cfg_active_slots,
  input  logic [SLOT_W-1:0] cfg_tx_slot,
  input  logic [CYC_W-1:0]  cfg_guard,
  input  logic [CYC_W-1:0]  cfg_turnaround,
  input  logic [SLOT_W-1:0] slot_n,
  input  logic [CYC_W-1:0]  cyc_n,
  input  logic              enter_sleep,
  input  logic              frame_wrap,
  output logic              frame_start,
  output logic              active,
  output logic              active_done,
  output logic [1:0]        slot_kind,
  output logic              radio_rx_en,
  output logic              radio_tx_en,
  output logic              tx_permit
);

  localparam int EXT_W = CYC_W + 1;

  slot_kind_e       kind_n;
  logic             tx_valid;
  logic             in_active;
  logic [EXT_W-1:0] cyc_ext;
  logic [EXT_W-1:0] len_ext;
  logic             turn_ok;
  logic             guard_ok;

  always_comb begin
    tx_valid  = cfg_tx_slot < cfg_active_slots;
    in_active = slot_n < cfg_active_slots;
    if (tx_valid && (slot_n == cfg_tx_slot)) begin
      kind_n = SK_TX;
    end else if (in_active) begin
      kind_n = SK_RX;
    end else begin
      kind_n = SK_SLEEP;
    end
    cyc_ext  = {1'b0, cyc_n};
    len_ext  = {1'b0, cfg_slot_len};
    turn_ok  = (cyc_n >= cfg_turnaround) && ((cyc_ext + {1'b0, cfg_turnaround}) < len_ext);
    guard_ok = (cyc_n >= cfg_guard) && ((cyc_ext + {1'b0, cfg_guard}) < len_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_start <= 1'b0;
      active      <= 1'b0;
      active_done <= 1'b0;
      slot_kind   <= SK_SLEEP;
      radio_rx_en <= 1'b0;
      radio_tx_en <= 1'b0;
      tx_permit   <= 1'b0;
    end else begin
      frame_start <= frame_wrap;
      active      <= in_active;
      active_done <= enter_sleep;
      slot_kind   <= kind_n;
      radio_rx_en <= (kind_n == SK_RX);
      radio_tx_en <= (kind_n == SK_TX) && turn_ok;
      tx_permit   <= (kind_n == SK_TX) && guard_ok;
    end
  end

  AST_RADIO_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(radio_rx_en && radio_tx_en)); // R7

  AST_PERMIT_INSIDE: assert property (@(posedge clk) disable iff (rst)
    tx_permit |-> radio_tx_en); // R8

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!radio_rx_en && !radio_tx_en && !tx_permit)); // R6

  AST_DONE_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    active_done |-> !active); // R4

  AST_TX_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (slot_kind == SK_TX) |-> (cfg_tx_slot < cfg_active_slots)); // R9

endmodule

// File: rtl/tdma_seq.sv
module tdma_seq #(
  parameter int CYC_W  = 12,
  parameter int SLOT_W = 6,
  parameter int CORR_W = CYC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CYC_W-1:0]         cfg_slot_len,
  input  logic [SLOT_W-1:0]        cfg_frame_slots,
  input  logic [SLOT_W-1:0]        cfg_active_slots,
  input  logic [SLOT_W-1:0]        cfg_tx_slot,
  input  logic [CYC_W-1:0]         cfg_guard,
  input  logic [CYC_W-1:0]         cfg_turnaround,
  input  logic                     corr_valid,
  input  logic signed [CORR_W-1:0] corr_value,
  output logic [SLOT_W-1:0]        slot_num,
  output logic                     frame_start,
  output logic                     active,
  output logic                     active_done,
  output logic [1:0]               slot_kind,
  output logic                     radio_rx_en,
  output logic                     radio_tx_en,
  output logic                     tx_permit
);

  logic [CYC_W-1:0]  skip_cyc;
  logic [CYC_W-1:0]  hold_cyc;
  logic              enter_sleep;
  logic              frame_wrap;
  logic [SLOT_W-1:0] slot_n;
  logic [CYC_W-1:0]  cyc_n;

  tdma_corr_unit #(.CYC_W(CYC_W), .CORR_W(CORR_W)) u_corr (
    .clk        (clk),
    .rst        (rst),
    .corr_valid (corr_valid),
    .corr_value (corr_value),
    .consume    (enter_sleep),
    .slot_len   (cfg_slot_len),
    .skip_cyc   (skip_cyc),
    .hold_cyc   (hold_cyc)
  );

  tdma_slot_counter #(.CYC_W(CYC_W), .SLOT_W(SLOT_W)) u_cnt (
    .clk              (clk),
    .rst              (rst),
    .cfg_slot_len     (cfg_slot_len),
    .cfg_frame_slots  (cfg_frame_slots),
    .cfg_active_slots (cfg_active_slots),
    .skip_cyc         (skip_cyc),
    .hold_cyc         (hold_cyc),
    .enter_sleep      (enter_sleep),
    .frame_wrap       (frame_wrap),
    .slot_q           (slot_num),
    .slot_n           (slot_n),
    .cyc_n            (cyc_n)
  );

  tdma_radio_ctl #(.CYC_W(CYC_W), .SLOT_W(SLOT_W)) u_radio (
    .clk              (clk),
    .rst              (rst),
    .cfg_slot_len     (cfg_slot_len),
    .cfg_active_slots (cfg_active_slots),
    .cfg_tx_slot      (cfg_tx_slot),
    .cfg_guard        (cfg_guard),
    .cfg_turnaround   (cfg_turnaround),
    .slot_n           (slot_n),
    .cyc_n            (cyc_n),
    .enter_sleep      (enter_sleep),
    .frame_wrap       (frame_wrap),
    .frame_start      (frame_start),
    .active           (active),
    .active_done      (active_done),
    .slot_kind        (slot_kind),
    .radio_rx_en      (radio_rx_en),
    .radio_tx_en      (radio_tx_en),
    .tx_permit        (tx_permit)
  );

endmodule

// File: tb/tdma_seq_bench.sv
`timescale 1ns/1ps
module tdma_seq_bench;

  localparam int CYC_W  = 12;
  localparam int SLOT_W = 6;
  localparam int CORR_W = CYC_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CYC_W-1:0]  cfg_slot_len = 12'd8;
  logic [SLOT_W-1:0] cfg_frame_slots = 6'd6;
  logic [SLOT_W-1:0] cfg_active_slots = 6'd3;
  logic [SLOT_W-1:0] cfg_tx_slot = 6'd1;
  logic [CYC_W-1:0]  cfg_guard = 12'd2;
  logic [CYC_W-1:0]  cfg_turnaround = 12'd1;
  logic corr_valid = 1'b0;
  logic signed [CORR_W-1:0] corr_value = '0;
  logic [SLOT_W-1:0] slot_num;
  logic frame_start, active, active_done, radio_rx_en, radio_tx_en, tx_permit;
  logic [1:0] slot_kind;

  always #4 clk = ~clk;

  tdma_seq #(.CYC_W(CYC_W), .SLOT_W(SLOT_W), .CORR_W(CORR_W)) u_tdma_seq (
    .clk(clk), .rst(rst), .cfg_slot_len(cfg_slot_len), .cfg_frame_slots(cfg_frame_slots),
    .cfg_active_slots(cfg_active_slots), .cfg_tx_slot(cfg_tx_slot), .cfg_guard(cfg_guard),
    .cfg_turnaround(cfg_turnaround), .corr_valid(corr_valid), .corr_value(corr_value),
    .slot_num(slot_num), .frame_start(frame_start), .active(active), .active_done(active_done),
    .slot_kind(slot_kind), .radio_rx_en(radio_rx_en), .radio_tx_en(radio_tx_en), .tx_permit(tx_permit)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference position built from the requirements
  int m_slot, m_cyc, m_stall, m_pend, m_corr, m_kind_corr;
  bit m_rst, e_frame, e_done;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at slot=%0d cyc=%0d", tag, what, act, exp, m_slot, m_cyc);
    end
  endtask

  always @(posedge clk) begin
    int len, frs, act_n, last;
    bit slot_end, frame_end, has_sleep, enter;
    len = int'(cfg_slot_len); frs = int'(cfg_frame_slots); act_n = int'(cfg_active_slots);
    if (rst) begin
      m_slot = 0; m_cyc = 0; m_stall = 0; m_pend = 0; m_corr = 0; m_kind_corr = 0;
      m_rst = 1; e_frame = 0; e_done = 0;
    end else begin
      m_rst = 0;
      last = len - 1;
      slot_end  = (m_stall == 0) && (m_cyc >= last);
      frame_end = slot_end && (m_slot >= frs - 1);
      has_sleep = (act_n != 0) && (act_n < frs);
      enter     = slot_end && has_sleep && (m_slot == act_n - 1);
      e_frame = frame_end; e_done = enter;
      if (frame_end) m_kind_corr = 0;
      if (m_stall != 0) m_stall--;
      else if (slot_end) begin
        m_cyc = 0;
        m_slot = frame_end ? 0 : m_slot + 1;
        if (enter && m_pend != 0) begin
          if (m_corr > 0) begin m_cyc = imin(m_corr, last); m_kind_corr = 1; end
          else if (m_corr < 0) begin m_stall = imin(-m_corr, last); m_kind_corr = 2; end
        end
      end else m_cyc++;
      if (corr_valid) begin m_pend = 1; m_corr = int'(corr_value); end
      else if (enter) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    int len, act_n, txs, g, w, ekind;
    bit tx_ok, sleep, is_tx;
    string st;
    if (!finished) begin
      if (m_rst) begin
        check("R12", "slot_num", int'(slot_num), 0);
        check("R12", "outputs", int'({frame_start, active, active_done, slot_kind,
              radio_rx_en, radio_tx_en, tx_permit}), 0);
      end else begin
        len = int'(cfg_slot_len); act_n = int'(cfg_active_slots); txs = int'(cfg_tx_slot);
        g = int'(cfg_guard); w = int'(cfg_turnaround);
        tx_ok = txs < act_n;
        sleep = m_slot >= act_n;
        is_tx = tx_ok && (m_slot == txs);
        ekind = is_tx ? 2 : (sleep ? 0 : 1);
        st = (m_kind_corr == 1) ? "R10" : ((m_kind_corr == 2) ? "R11" : "R1");
        check(st, "slot_num", int'(slot_num), m_slot);
        check("R2", "frame_start", int'(frame_start), int'(e_frame));
        check("R3", "active", int'(active), int'(!sleep));
        check("R4", "active_done", int'(active_done), int'(e_done));
        check(tx_ok ? "R5" : "R9", "slot_kind", int'(slot_kind), ekind);
        check(sleep ? "R6" : "R5", "radio_rx_en", int'(radio_rx_en), int'(ekind == 1));
        check(sleep ? "R6" : (tx_ok ? "R7" : "R9"), "radio_tx_en", int'(radio_tx_en),
              int'(is_tx && m_cyc >= w && m_cyc + w <= len - 1));
        check(sleep ? "R6" : (tx_ok ? "R8" : "R9"), "tx_permit", int'(tx_permit),
              int'(is_tx && m_cyc >= g && m_cyc + g <= len - 1));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic run_cfg(int len, int frs, int act_n, int txs, int g, int w, int cycles, int corr_rate);
    @(negedge clk); #1;
    rst = 1'b1; corr_valid = 1'b0;
    cfg_slot_len = CYC_W'(len); cfg_frame_slots = SLOT_W'(frs);
    cfg_active_slots = SLOT_W'(act_n); cfg_tx_slot = SLOT_W'(txs);
    cfg_guard = CYC_W'(g); cfg_turnaround = CYC_W'(w);
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #1;
      if (corr_rate != 0 && ($urandom % corr_rate) == 0) begin
        corr_valid = 1'b1;
        corr_value = CORR_W'(int'($urandom % (2 * len + 9)) - (len + 4));
      end else corr_valid = 1'b0;
    end
    corr_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int len, frs, act_n;
    void'($urandom(32'd20240611));
    // directed: baseline with no correction, then heavy correction traffic
    run_cfg(8, 6, 3, 1, 2, 1, 400, 0);
    run_cfg(8, 6, 3, 1, 2, 1, 1200, 15);
    // transmit slot just past the active run: receive only
    run_cfg(10, 5, 2, 2, 3, 2, 400, 20);
    // no sleep slots: correction never consumed
    run_cfg(6, 4, 4, 3, 1, 1, 400, 10);
    // no active slots
    run_cfg(5, 3, 0, 0, 1, 0, 200, 10);
    // transmit in slot 0, single-slot frame edge, minimum slot length
    run_cfg(12, 3, 1, 0, 5, 5, 500, 12);
    run_cfg(1, 1, 1, 0, 0, 0, 50, 5);
    for (int k = 0; k < 18; k++) begin
      len = 4 + int'($urandom % 37);
      frs = 1 + int'($urandom % 12);
      act_n = int'($urandom % (frs + 1));
      begin
        int txs, g, w;
        txs = int'($urandom % (act_n + 2));
        g = int'($urandom % ((len - 1) / 2 + 1));
        w = int'($urandom % (g + 1));
        run_cfg(len, frs, act_n, txs, g, w, 1200, 1 + int'($urandom % 40));
      end
    end
    @(negedge clk);
    finish_run();
  end

endmodule